// File: doc/BRIEF.md
# Parcel Dispatcher to Run-to-Completion Engines

The dispatcher takes header parcels (up to 256 bytes of packet header, sent as 64-bit beats with first and last markers; the payload never passes through here) from a buffering interface and steers each parcel to one of a set of parallel processing engines. Each engine can hold a fixed number of parcels in flight, one per context. The dispatcher keeps a busy map per engine. When a parcel starts, it picks an engine by rotating priority and a free context within that engine. It then labels every beat of the parcel with an engine and context tag.

Engines run for a variable time per parcel, and each parcel makes a single pass. The return path forwards finished beats, with their tags, back to the buffering side. The last accepted beat of a parcel releases its context. Order is kept only inside one engine, and keeping it is the engine's duty. The dispatcher makes no promise about order across engines.

The control is a two-state machine. PICK waits for a parcel start and chooses the tag. STREAM holds the tag until the last beat. The transitions are:
- PICK goes to STREAM when a first beat is accepted that is not also a last beat.
- PICK stays in PICK when a single-beat parcel is accepted.
- STREAM goes back to PICK when the last beat is accepted.

Top module: `parcel_dispatch`

## Requirements
- R1: After reset every context of every engine is free, rotation starts at engine 0, the machine is in PICK, and no beat is presented on either output.
- R2: With all engines free, successive parcels go to engines 0, 1, 2, … in order, wrapping after the last engine.
- R3: If the engine next in rotation has no free context, the parcel goes to the first engine after it, in rotation order, that has one.
- R4: Within the chosen engine, the lowest-numbered free context is used.
- R5: The engine and context chosen at a parcel's first beat label every later beat of that parcel, unchanged, up to and including its last beat.
- R6: In PICK with no free context anywhere, in_ready and disp_valid are both 0 even while in_valid is 1.
- R7: disp_data, disp_first and disp_last equal the input beat in the same cycle, and in_ready is 0 whenever disp_ready is 0.
- R8: Returned beats pass through in the same cycle: out_valid, out_data, out_first, out_last, out_eng and out_ctx copy the ret_* inputs, and ret_ready equals out_ready.
- R9: A context is released only by a returned beat with ret_last at 1 that is accepted (ret_valid and out_ready both 1). It is free for a dispatch in the next cycle. A non-last beat, or a last beat that is not accepted, releases nothing.
- R10: After a dispatch to engine e, rotation resumes from engine e+1 (modulo the engine count), whichever engine was preferred before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 64 | Input header beat |
| in_first | input | 1 | First beat of parcel |
| in_last | input | 1 | Last beat of parcel |
| disp_valid | output | 1 | Beat offered to engines |
| disp_ready | input | 1 | Engine side accepts beat |
| disp_data | output | 64 | Beat to engine |
| disp_first | output | 1 | First-beat marker to engine |
| disp_last | output | 1 | Last-beat marker to engine |
| disp_eng | output | 4 | Target engine index |
| disp_ctx | output | 5 | Target context index |
| ret_valid | input | 1 | Completed beat from engines valid |
| ret_ready | output | 1 | Completed beat accepted |
| ret_data | input | 64 | Completed beat data |
| ret_first | input | 1 | First beat of completed parcel |
| ret_last | input | 1 | Last beat of completed parcel |
| ret_eng | input | 4 | Engine tag of completed parcel |
| ret_ctx | input | 5 | Context tag of completed parcel |
| out_valid | output | 1 | Beat to buffering side valid |
| out_ready | input | 1 | Buffering side accepts beat |
| out_data | output | 64 | Beat to buffering side |
| out_first | output | 1 | First-beat marker |
| out_last | output | 1 | Last-beat marker |
| out_eng | output | 4 | Engine tag |
| out_ctx | output | 5 | Context tag |

## Verification
The handshake and tag outputs are combinational, so they are due in the same cycle as the input beat. The bench drives each beat on the falling edge and samples one nanosecond later, before the rising edge that accepts it. A dispatch or a release changes the busy map at the accepting rising edge, so its effect is first visible in the next cycle. The bench therefore checks tag choice and backpressure only on the beat offered after that edge. A failed release, such as a non-last beat or an unaccepted last beat, shows up as a later tag that skips the still-busy context.

// File: rtl/parcel_dispatch_pkg.sv
package parcel_dispatch_pkg;
    typedef enum logic {
        ST_PICK   = 1'b0,
        ST_STREAM = 1'b1
    } dsp_state_e;
endpackage

// File: rtl/ctx_pool.sv
module ctx_pool #(
    parameter int N_CTX = 20,
    localparam int CTX_W = $clog2(N_CTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [CTX_W-1:0] alloc_ctx,
    input  logic             free_en,
    input  logic [CTX_W-1:0] free_ctx,
    output logic             has_free,
    output logic [CTX_W-1:0] low_ctx
);
    logic [N_CTX-1:0] busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
        end else begin
            for (int i = 0; i < N_CTX; i++) begin
                if (alloc_en && alloc_ctx == CTX_W'(i)) busy[i] <= 1'b1;
                else if (free_en && free_ctx == CTX_W'(i)) busy[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        has_free = 1'b0;
        low_ctx  = '0;
        for (int i = N_CTX - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                has_free = 1'b1;
                low_ctx  = CTX_W'(i);
            end
        end
    end

    // R4: a context is only handed out while idle
    a_r4_alloc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !busy[alloc_ctx]);

    // R9: a release targets a context that is in flight
    a_r9_free_busy: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> busy[free_ctx]);
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] ptr,
    output logic             any,
    output logic [IDX_W-1:0] gnt
);
    int idx;

    always_comb begin
        any = 1'b0;
        gnt = '0;
        idx = 0;
        for (int k = N - 1; k >= 0; k--) begin
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (req[idx]) begin
                any = 1'b1;
                gnt = IDX_W'(idx);
            end
        end
    end
endmodule

// File: rtl/parcel_dispatch.sv
module parcel_dispatch
    import parcel_dispatch_pkg::*;
#(
    parameter int N_ENG  = 16,
    parameter int N_CTX  = 20,
    parameter int BEAT_W = 64,
    localparam int ENG_W = $clog2(N_ENG),
    localparam int CTX_W = $clog2(N_CTX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BEAT_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [BEAT_W-1:0] disp_data,
    output logic              disp_first,
    output logic              disp_last,
    output logic [ENG_W-1:0]  disp_eng,
    output logic [CTX_W-1:0]  disp_ctx,
    input  logic              ret_valid,
    output logic              ret_ready,
    input  logic [BEAT_W-1:0] ret_data,
    input  logic              ret_first,
    input  logic              ret_last,
    input  logic [ENG_W-1:0]  ret_eng,
    input  logic [CTX_W-1:0]  ret_ctx,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BEAT_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last,
    output logic [ENG_W-1:0]  out_eng,
    output logic [CTX_W-1:0]  out_ctx
);
    dsp_state_e             st, st_nx;
    logic [ENG_W-1:0]       rr_ptr;
    logic [ENG_W-1:0]       hold_eng;
    logic [CTX_W-1:0]       hold_ctx;
    logic [N_ENG-1:0]       pool_free;
    logic [CTX_W-1:0]       pool_low [N_ENG];
    logic                   any_free;
    logic [ENG_W-1:0]       pick_eng;
    logic                   beat_acc;
    logic                   start_acc;
    logic                   ret_done;

    rr_pick #(.N(N_ENG)) u_pick (
        .req (pool_free),
        .ptr (rr_ptr),
        .any (any_free),
        .gnt (pick_eng)
    );

    assign beat_acc  = in_valid && in_ready;
    assign start_acc = beat_acc && (st == ST_PICK);
    assign ret_done  = ret_valid && out_ready && ret_last;

    for (genvar e = 0; e < N_ENG; e++) begin : g_eng
        ctx_pool #(.N_CTX(N_CTX)) u_pool (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_en  (start_acc && pick_eng == ENG_W'(e)),
            .alloc_ctx (pool_low[e]),
            .free_en   (ret_done && ret_eng == ENG_W'(e)),
            .free_ctx  (ret_ctx),
            .has_free  (pool_free[e]),
            .low_ctx   (pool_low[e])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_PICK;
            rr_ptr   <= '0;
            hold_eng <= '0;
            hold_ctx <= '0;
        end else begin
            st <= st_nx;
            if (start_acc) begin
                hold_eng <= pick_eng;
                hold_ctx <= pool_low[pick_eng];
                rr_ptr   <= (int'(pick_eng) == N_ENG - 1) ? '0 : pick_eng + 1'b1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        st_nx      = st;
        in_ready   = 1'b0;
        disp_valid = 1'b0;
        disp_eng   = hold_eng;
        disp_ctx   = hold_ctx;
        unique case (st)
            ST_PICK: begin
                in_ready   = disp_ready && any_free;
                disp_valid = in_valid && any_free;
                disp_eng   = pick_eng;
                disp_ctx   = pool_low[pick_eng];
                if (in_valid && in_ready && !in_last) st_nx = ST_STREAM;
            end
            ST_STREAM: begin
                in_ready   = disp_ready;
                disp_valid = in_valid;
                if (in_valid && in_ready && in_last) st_nx = ST_PICK;
            end
        endcase
    end

    assign disp_data  = in_data;
    assign disp_first = in_first;
    assign disp_last  = in_last;

    assign out_valid  = ret_valid;
    assign ret_ready  = out_ready;
    assign out_data   = ret_data;
    assign out_first  = ret_first;
    assign out_last   = ret_last;
    assign out_eng    = ret_eng;
    assign out_ctx    = ret_ctx;

    // R5: tag unchanged between beats of one parcel
    a_r5_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready && !disp_last) |=>
            (disp_eng == $past(disp_eng) && disp_ctx == $past(disp_ctx)));

    // R6: no start offered while every context is busy
    a_r6_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PICK && pool_free == '0) |-> (!in_ready && !disp_valid));

    // R9: a released engine has room in the next cycle
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done |=> pool_free[$past(ret_eng)]);

    // R7: no acceptance without downstream ready
    a_r7_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_ready |-> !in_ready);
endmodule

// File: tb/parcel_dispatch_test.sv
`timescale 1ns/1ps
module parcel_dispatch_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0, in_first = 0, in_last = 0;
    logic [63:0] in_data = '0;
    logic        in_ready;
    logic        disp_valid, disp_first, disp_last;
    logic        disp_ready = 1;
    logic [63:0] disp_data;
    logic [3:0]  disp_eng;
    logic [4:0]  disp_ctx;
    logic        ret_valid = 0, ret_first = 0, ret_last = 0;
    logic [63:0] ret_data = '0;
    logic [3:0]  ret_eng = '0;
    logic [4:0]  ret_ctx = '0;
    logic        ret_ready;
    logic        out_valid, out_first, out_last;
    logic        out_ready = 0;
    logic [63:0] out_data;
    logic [3:0]  out_eng;
    logic [4:0]  out_ctx;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    parcel_dispatch uut (.*);

    // {first, last, eng[3:0], ctx[4:0]}
    localparam logic [10:0] VEC [20] = '{
        {2'b11, 4'd0,  5'd0}, {2'b11, 4'd1,  5'd0}, {2'b11, 4'd2,  5'd0},
        {2'b11, 4'd3,  5'd0}, {2'b11, 4'd4,  5'd0}, {2'b11, 4'd5,  5'd0},
        {2'b11, 4'd6,  5'd0}, {2'b11, 4'd7,  5'd0}, {2'b11, 4'd8,  5'd0},
        {2'b11, 4'd9,  5'd0}, {2'b11, 4'd10, 5'd0}, {2'b11, 4'd11, 5'd0},
        {2'b11, 4'd12, 5'd0}, {2'b11, 4'd13, 5'd0}, {2'b11, 4'd14, 5'd0},
        {2'b11, 4'd15, 5'd0},
        {2'b10, 4'd0,  5'd1}, {2'b00, 4'd0,  5'd1}, {2'b01, 4'd0,  5'd1},
        {2'b11, 4'd1,  5'd1}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic beat(input logic f, input logic l, input logic [63:0] d,
                        input int ee, input int ec, input string req);
        @(negedge clk);
        in_valid = 1; in_first = f; in_last = l; in_data = d;
        #1;
        chk(in_ready === 1'b1, req, in_ready, 1);
        chk(disp_eng == 4'(ee) && disp_ctx == 5'(ec), req,
            {disp_eng, disp_ctx}, {4'(ee), 5'(ec)});
        chk(disp_data == d && disp_first == f && disp_last == l, "R7", disp_data, d);
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic give_back(input int e, input int c, input logic l, input logic ordy);
        @(negedge clk);
        ret_valid = 1; ret_eng = 4'(e); ret_ctx = 5'(c); ret_last = l; ret_first = 1;
        ret_data = 64'hC0DE_0000 + 64'(e * 32 + c); out_ready = ordy;
        #1;
        chk(out_valid && out_eng == 4'(e) && out_ctx == 5'(c) && out_last == l
            && out_data == ret_data && ret_ready == ordy, "R8", {out_eng, out_ctx}, e * 32 + c);
        @(posedge clk); #1;
        ret_valid = 0; out_ready = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int acc;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        // R1: reset state
        chk(in_ready === 1'b1 && disp_valid === 1'b0 && out_valid === 1'b0, "R1",
            {in_ready, disp_valid, out_valid}, 3'b100);
        chk(disp_eng == 0 && disp_ctx == 0, "R1", {disp_eng, disp_ctx}, 0);

        // R7: downstream not ready blocks acceptance
        disp_ready = 0; in_valid = 1; in_first = 1; in_last = 1;
        #1;
        chk(in_ready === 1'b0 && disp_valid === 1'b1, "R7", {in_ready, disp_valid}, 2'b01);
        @(negedge clk);
        in_valid = 0; disp_ready = 1;

        // table: R2 rotation, R5 tag hold, R4 next context
        for (int i = 0; i < 20; i++) begin
            beat(VEC[i][10], VEC[i][9], 64'hA000 + 64'(i), int'(VEC[i][8:5]), int'(VEC[i][4:0]),
                 (i < 16) ? "R2" : (i < 19 ? "R5" : "R4"));
        end

        // R9: non-last and unaccepted last release nothing; accepted last releases
        give_back(1, 0, 1'b0, 1'b1);
        give_back(1, 1, 1'b1, 1'b0);
        give_back(0, 0, 1'b1, 1'b1);
        for (int e = 2; e < 16; e++) beat(1, 1, 64'hB000 + 64'(e), e, 1, "R2");
        beat(1, 1, 64'hB100, 0, 0, "R9");
        beat(1, 1, 64'hB101, 1, 2, "R9");

        // fill every context: 320 total, 33 in flight now
        acc = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            in_valid = 1; in_first = 1; in_last = 1;
            #1;
            if (!in_ready) break;
            @(posedge clk); #1;
            acc++;
        end
        chk(acc == 287, "R6", acc, 287);
        chk(in_ready === 1'b0 && disp_valid === 1'b0, "R6", {in_ready, disp_valid}, 0);
        @(negedge clk);
        in_valid = 0;

        // R3: only engine 5 has room
        give_back(5, 7, 1'b1, 1'b1);
        beat(1, 1, 64'hD005, 5, 7, "R3");
        // R10: rotation resumes after engine 5
        give_back(3, 4, 1'b1, 1'b1);
        give_back(9, 2, 1'b1, 1'b1);
        beat(1, 1, 64'hD009, 9, 2, "R10");
        beat(1, 1, 64'hD003, 3, 4, "R10");
        @(negedge clk);
        in_valid = 1;
        #1;
        chk(in_ready === 1'b0, "R6", in_ready, 0);
        @(negedge clk);
        in_valid = 0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule